// File: doc/BRIEF.md
# Multicycle Issue Hazard Checker

This block sits in the decode stage of an in-order pipeline. The pipeline has four execute units with different latencies: a one-cycle integer unit, a pipelined adder, a pipelined multiplier and an unpipelined divider. All four units share a single register-file write port. Each cycle the block looks at the decoded candidate instruction and decides whether it issues or stays in decode.

An instruction stays in decode when any of four conditions holds:
- its execute unit cannot accept it;
- one of its source registers still awaits a result;
- an older instruction, still in flight, would write the same destination later;
- the cycle in which its own result would reach the write port is already promised to another instruction.

A stalled instruction is held unchanged at the inputs and is evaluated again every cycle. A write-port reservation ring and a per-register pending mask are exposed, so that the surrounding pipeline can see what has been promised. Forwarding paths and the units themselves lie outside the block.

Top module: `issue_hazard_chk`

## Requirements
- R1: While reset is low, and after it is released, `wb_resv` and `pend_mask` are all zero. The first instruction presented after reset issues in the cycle it is presented.
- R2: The unit codes are 0 integer, 1 adder, 2 multiplier and 3 divider. Their default latencies L are 1, 4, 7 and 24 cycles, where the result is written L cycles after the issue cycle. Bit i of `wb_resv` means the write port is taken i+1 cycles from now. A writing instruction with L of 2 or more that issues sets bit L-2 in the next cycle. Every bit moves down one place per cycle.
- R3: The divider holds one operation. After a divide issues in cycle t, a second divide stalls with cause 1 and issues no earlier than cycle t+24.
- R4: The adder and the multiplier accept a new operation every cycle. Back-to-back writers with distinct registers issue without stalling.
- R5: An instruction whose source matches a register with a pending write stalls with cause 2. It issues in the cycle that write reaches the port. Bit r of `pend_mask` is set while register r awaits a write one or more cycles ahead. A latency-1 writer never sets its bit.
- R6: A writer whose destination still has a pending write due at least L cycles ahead stalls with cause 3. When the older write is due fewer than L cycles ahead, the writer issues.
- R7: A writer whose write cycle is already reserved in `wb_resv` stalls with cause 4. It issues in the first cycle in which its write cycle is free.
- R8: When several conditions hold at once, `stall_cause` reports the first in the order unit busy (1), source pending (2), destination ordering (3), port taken (4). A value of 0 means no stall. `issue` and `stall` are never both high.
- R9: An instruction with `dec_wr_en` low skips the destination-ordering and port checks. It reserves no port cycle and marks no register pending.
- R10: With `dec_valid` low, `issue` and `stall` are low and `stall_cause` is 0. No state changes except the one-place shift of the existing reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | A candidate instruction is present in decode |
| dec_unit | input | 2 | Execute unit code: 0 int, 1 add, 2 mul, 3 div |
| dec_wr_en | input | 1 | Instruction writes a destination register |
| dec_dst | input | RW (5) | Destination register number |
| dec_src_a | input | RW (5) | First source register number |
| dec_src_b | input | RW (5) | Second source register number |
| issue | output | 1 | Candidate issues at the end of this cycle |
| stall | output | 1 | Candidate is held in decode |
| stall_cause | output | 3 | Reason for the stall: 0 none, 1 unit, 2 source, 3 destination, 4 port |
| wb_resv | output | MAXL (24) | Write-port reservation ring, bit i = taken i+1 cycles ahead |
| pend_mask | output | NREG (32) | Registers with a write still to come |

## Verification
The hardest situation to reach is a writer that meets a destination-ordering hazard and a port collision in the same cycle. That cycle only arises after an exact gap following a long-latency write to the same register.

The stimulus issues a multiply, leaves decode empty for exactly two cycles, and then presents an add to the same register. At that point the older write is four cycles out, which is equal to the add's latency, and its port slot coincides with the add's. This shows that the ordering cause wins the priority, and that the add issues in the very next cycle.

The divide-after-divide and divide-then-add cases also need exact cycle counts of 23 and 20 stalled cycles, which the directed tasks measure.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_ADD = 2'd1,
        UNIT_MUL = 2'd2,
        UNIT_DIV = 2'd3
    } unit_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_UNIT = 3'd1,
        CAUSE_RAW  = 3'd2,
        CAUSE_WAW  = 3'd3,
        CAUSE_PORT = 3'd4
    } cause_e;

endpackage

// File: rtl/ihc_unit_track.sv
// Occupancy of one execute unit: an op issued in cycle t is counted
// from t+1 to t+LAT-1, and the unit is full at DEPTH outstanding ops.
module ihc_unit_track #(
    parameter int LAT   = 4,
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic full
);
    localparam int VW     = LAT - 1;
    localparam int SETBIT = LAT - 2;

    typedef struct packed {
        logic [VW-1:0] occ;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d.occ = s_q.occ >> 1;
        if (take) begin
            s_d.occ[SETBIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full = ($countones(s_q.occ) >= DEPTH);

endmodule

// File: rtl/ihc_wb_ring.sv
// Write-port reservation ring: bit k = port taken k+1 cycles ahead.
module ihc_wb_ring #(
    parameter int W  = 24,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [CW-1:0] lat,
    output logic [W-1:0]  ring,
    output logic          taken
);
    typedef struct packed {
        logic [W-1:0] ring;
    } ring_t;

    ring_t s_d, s_q;

    always_comb begin
        s_d.ring = s_q.ring >> 1;
        taken    = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (k + 1 == int'(lat)) begin
                taken = s_q.ring[k];
            end
            if (take && (k + 2 == int'(lat))) begin
                s_d.ring[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ring = s_q.ring;

endmodule

// File: rtl/ihc_scoreboard.sv
// Per-register count of cycles until the pending write reaches the port.
module ihc_scoreboard #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int CW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   dst,
    input  logic [CW-1:0]   lat,
    input  logic [RW-1:0]   src_a,
    input  logic [RW-1:0]   src_b,
    output logic            raw_hit,
    output logic            waw_hit,
    output logic [NREG-1:0] pend
);
    typedef struct packed {
        logic [NREG-1:0][CW-1:0] cnt;
    } sb_t;

    sb_t s_d, s_q;

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            s_d.cnt[r] = (s_q.cnt[r] != '0) ? s_q.cnt[r] - CW'(1) : '0;
            if (we && (dst == RW'(r))) begin
                s_d.cnt[r] = lat - CW'(1);
            end
            pend[r] = (s_q.cnt[r] != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raw_hit = pend[src_a] | pend[src_b];
    assign waw_hit = (s_q.cnt[dst] >= lat);

endmodule

// File: rtl/issue_hazard_chk.sv
module issue_hazard_chk
    import ihc_pkg::*;
#(
    parameter int NREG      = 32,
    parameter int RW        = 5,
    parameter int LAT_INT   = 1,
    parameter int LAT_ADD   = 4,
    parameter int LAT_MUL   = 7,
    parameter int LAT_DIV   = 24,
    parameter int DEPTH_INT = 1,
    parameter int DEPTH_ADD = 4,
    parameter int DEPTH_MUL = 7,
    parameter int DEPTH_DIV = 1,
    localparam int MAX_A    = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD,
    localparam int MAX_B    = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV,
    localparam int MAXL     = (MAX_A > MAX_B) ? MAX_A : MAX_B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [1:0]      dec_unit,
    input  logic            dec_wr_en,
    input  logic [RW-1:0]   dec_dst,
    input  logic [RW-1:0]   dec_src_a,
    input  logic [RW-1:0]   dec_src_b,
    output logic            issue,
    output logic            stall,
    output logic [2:0]      stall_cause,
    output logic [MAXL-1:0] wb_resv,
    output logic [NREG-1:0] pend_mask
);
    localparam int CW = $clog2(MAXL + 1);

    unit_e         unit;
    logic [CW-1:0] lat_sel;
    logic [3:0]    unit_full;
    logic          sb_raw, sb_waw, port_taken;
    cause_e        cause;

    assign unit = unit_e'(dec_unit);

    always_comb begin
        case (unit)
            UNIT_INT: lat_sel = CW'(LAT_INT);
            UNIT_ADD: lat_sel = CW'(LAT_ADD);
            UNIT_MUL: lat_sel = CW'(LAT_MUL);
            default:  lat_sel = CW'(LAT_DIV);
        endcase
    end

    // One occupancy tracker per unit whose latency spans several cycles.
    for (genvar g = 0; g < 4; g++) begin : g_unit
        localparam int LG = (g == 0) ? LAT_INT : (g == 1) ? LAT_ADD :
                            (g == 2) ? LAT_MUL : LAT_DIV;
        localparam int DG = (g == 0) ? DEPTH_INT : (g == 1) ? DEPTH_ADD :
                            (g == 2) ? DEPTH_MUL : DEPTH_DIV;
        if (LG >= 2) begin : g_trk
            ihc_unit_track #(
                .LAT   (LG),
                .DEPTH (DG)
            ) u_trk (
                .clk   (clk),
                .rst_n (rst_n),
                .take  (issue && (dec_unit == 2'(g))),
                .full  (unit_full[g])
            );
        end else begin : g_none
            assign unit_full[g] = 1'b0;
        end
    end

    ihc_scoreboard #(
        .NREG (NREG),
        .RW   (RW),
        .CW   (CW)
    ) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (issue && dec_wr_en),
        .dst     (dec_dst),
        .lat     (lat_sel),
        .src_a   (dec_src_a),
        .src_b   (dec_src_b),
        .raw_hit (sb_raw),
        .waw_hit (sb_waw),
        .pend    (pend_mask)
    );

    ihc_wb_ring #(
        .W  (MAXL),
        .CW (CW)
    ) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (issue && dec_wr_en),
        .lat   (lat_sel),
        .ring  (wb_resv),
        .taken (port_taken)
    );

    // Checks in fixed order: unit, source, destination ordering, port.
    always_comb begin
        if (unit_full[dec_unit]) begin
            cause = CAUSE_UNIT;
        end else if (sb_raw) begin
            cause = CAUSE_RAW;
        end else if (dec_wr_en && sb_waw) begin
            cause = CAUSE_WAW;
        end else if (dec_wr_en && port_taken) begin
            cause = CAUSE_PORT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    assign issue       = dec_valid && (cause == CAUSE_NONE);
    assign stall       = dec_valid && (cause != CAUSE_NONE);
    assign stall_cause = dec_valid ? cause : CAUSE_NONE;

endmodule

// File: rtl/issue_hazard_chk_sva.sv
module issue_hazard_chk_sva #(
    parameter int NREG      = 32,
    parameter int RW        = 5,
    parameter int LAT_INT   = 1,
    parameter int LAT_ADD   = 4,
    parameter int LAT_MUL   = 7,
    parameter int LAT_DIV   = 24,
    parameter int DEPTH_DIV = 1,
    parameter int MAXL      = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_valid,
    input logic [1:0]      dec_unit,
    input logic            dec_wr_en,
    input logic [RW-1:0]   dec_dst,
    input logic [RW-1:0]   dec_src_a,
    input logic [RW-1:0]   dec_src_b,
    input logic            issue,
    input logic            stall,
    input logic [2:0]      stall_cause,
    input logic [MAXL-1:0] wb_resv,
    input logic [NREG-1:0] pend_mask
);
    localparam int GW = $clog2(LAT_DIV + 1);

    function automatic int lat_of(input logic [1:0] u);
        case (u)
            2'd0:    return LAT_INT;
            2'd1:    return LAT_ADD;
            2'd2:    return LAT_MUL;
            default: return LAT_DIV;
        endcase
    endfunction

    // Cycles since the last divide issued, saturating.
    logic [GW-1:0] div_gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_gap_q <= GW'(LAT_DIV);
        end else if (issue && dec_unit == 2'd3) begin
            div_gap_q <= GW'(1);
        end else if (div_gap_q < GW'(LAT_DIV)) begin
            div_gap_q <= div_gap_q + GW'(1);
        end
    end

    if (DEPTH_DIV == 1) begin : g_div
        a_r3_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && dec_unit == 2'd3) |-> (div_gap_q >= GW'(LAT_DIV)));
    end

    a_r2_resv_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && dec_wr_en) |=> (wb_resv == ($past(wb_resv) >> 1)));

    a_r2_mul_resv: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_wr_en && dec_unit == 2'd2) |=> wb_resv[LAT_MUL-2]);

    a_r5_raw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!pend_mask[dec_src_a] && !pend_mask[dec_src_b]));

    a_r7_port_free: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_wr_en) |-> !wb_resv[lat_of(dec_unit)-1]);

    a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall) && (stall == (stall_cause != 3'd0)));

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!issue && !stall && stall_cause == 3'd0));

endmodule

bind issue_hazard_chk issue_hazard_chk_sva #(
    .NREG      (NREG),
    .RW        (RW),
    .LAT_INT   (LAT_INT),
    .LAT_ADD   (LAT_ADD),
    .LAT_MUL   (LAT_MUL),
    .LAT_DIV   (LAT_DIV),
    .DEPTH_DIV (DEPTH_DIV),
    .MAXL      (MAXL)
) u_sva (.*);

// File: tb/issue_hazard_chk_bench.sv
module issue_hazard_chk_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [1:0]  dec_unit = 2'd0;
    logic        dec_wr_en = 1'b0;
    logic [4:0]  dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic        issue, stall;
    logic [2:0]  stall_cause;
    logic [23:0] wb_resv;
    logic [31:0] pend_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    issue_hazard_chk u_issue_hazard_chk (.*);

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic present(input bit v, input int u, input bit we,
                           input int d, input int a, input int b);
        dec_valid = v;
        dec_unit  = 2'(u);
        dec_wr_en = we;
        dec_dst   = 5'(d);
        dec_src_a = 5'(a);
        dec_src_b = 5'(b);
    endtask

    task automatic idle();
        present(0, 0, 0, 0, 0, 0);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    // Instruction must issue in the cycle it is presented.
    task automatic issue_now(input string req, input int u, input bit we,
                             input int d, input int a, input int b);
        present(1, u, we, d, a, b);
        #1;
        chk(req, "immediate issue", longint'(issue), 1);
        tick();
        idle();
    endtask

    // Holds the presented instruction until it issues; n = stalled cycles.
    task automatic hold_until_issue(output int n, output int c0);
        #1;
        c0 = int'(stall_cause);
        n  = 0;
        while (!issue && n < 200) begin
            tick();
            #1;
            n++;
        end
        tick();
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", "wb_resv after reset", longint'(wb_resv), 0);
        chk("R1", "pend_mask after reset", longint'(pend_mask), 0);
        chk("R1", "issue while idle", longint'(issue), 0);
        issue_now("R1", 0, 1, 1, 2, 3);
    endtask

    task automatic t_ring();
        do_reset();
        issue_now("R2", 2, 1, 1, 8, 9);
        #1;
        chk("R2", "mul reservation bit", longint'(wb_resv), 32'h20);
        issue_now("R2", 1, 1, 2, 8, 9);
        #1;
        chk("R2", "mul+add reservations", longint'(wb_resv), 32'h14);
        chk("R2", "pending r1 r2", longint'(pend_mask), 32'h6);
        tick();
        #1;
        chk("R2", "reservations shifted", longint'(wb_resv), 32'h0A);
    endtask

    task automatic t_div();
        int n, c;
        do_reset();
        issue_now("R3", 3, 1, 1, 10, 11);
        present(1, 3, 1, 2, 12, 13);
        hold_until_issue(n, c);
        chk("R3", "second divide stall cause", c, 1);
        chk("R3", "second divide stall cycles", n, 23);
    endtask

    task automatic t_pipe();
        do_reset();
        for (int i = 0; i < 4; i++) issue_now("R4", 1, 1, 1 + i, 20, 21);
        do_reset();
        for (int i = 0; i < 7; i++) issue_now("R4", 2, 1, 1 + i, 20, 21);
    endtask

    task automatic t_raw();
        int n, c;
        do_reset();
        issue_now("R5", 2, 1, 3, 10, 11);
        present(1, 0, 1, 4, 3, 0);
        #1;
        chk("R5", "pend_mask r3 set", longint'(pend_mask[3]), 1);
        hold_until_issue(n, c);
        chk("R5", "raw stall cause", c, 2);
        chk("R5", "raw stall cycles", n, 6);
        #1;
        chk("R5", "pend_mask r3 cleared", longint'(pend_mask[3]), 0);
        issue_now("R5", 0, 1, 6, 10, 11);
        #1;
        chk("R5", "latency-1 writer not pending", longint'(pend_mask[6]), 0);
        issue_now("R5", 0, 1, 7, 6, 6);
    endtask

    task automatic t_waw();
        int n, c;
        do_reset();
        issue_now("R6", 3, 1, 5, 10, 11);
        present(1, 1, 1, 5, 12, 13);
        hold_until_issue(n, c);
        chk("R6", "div/add waw cause", c, 3);
        chk("R6", "div/add waw cycles", n, 20);
        do_reset();
        issue_now("R6", 2, 1, 5, 10, 11);
        present(1, 1, 1, 5, 12, 13);
        hold_until_issue(n, c);
        chk("R6", "mul/add waw cause", c, 3);
        chk("R6", "mul/add waw cycles", n, 3);
    endtask

    task automatic t_port();
        int n, c;
        do_reset();
        issue_now("R7", 2, 1, 7, 10, 11);
        tick();
        tick();
        present(1, 1, 1, 8, 12, 13);
        hold_until_issue(n, c);
        chk("R7", "port conflict cause", c, 4);
        chk("R7", "port conflict cycles", n, 1);
    endtask

    task automatic t_prio();
        int n, c;
        do_reset();
        issue_now("R8", 3, 1, 1, 10, 11);
        present(1, 3, 1, 1, 1, 1);
        #1;
        chk("R8", "unit beats raw/waw", longint'(stall_cause), 1);
        chk("R8", "stall flag", longint'(stall), 1);
        chk("R8", "issue low while stalled", longint'(issue), 0);
        do_reset();
        issue_now("R8", 2, 1, 2, 10, 11);
        present(1, 1, 1, 2, 2, 12);
        #1;
        chk("R8", "raw beats waw", longint'(stall_cause), 2);
        do_reset();
        issue_now("R8", 2, 1, 2, 10, 11);
        tick();
        tick();
        present(1, 1, 1, 2, 20, 21);
        hold_until_issue(n, c);
        chk("R8", "waw beats port", c, 3);
        chk("R8", "issue after combined hazard", n, 1);
    endtask

    task automatic t_nowrite();
        do_reset();
        issue_now("R9", 2, 1, 7, 10, 11);
        tick();
        tick();
        issue_now("R9", 1, 0, 7, 20, 21);
        #1;
        chk("R9", "no reservation added", longint'(wb_resv), 32'h4);
        chk("R9", "no pending added", longint'(pend_mask), 32'h80);
    endtask

    task automatic t_invalid();
        do_reset();
        issue_now("R10", 3, 1, 1, 10, 11);
        present(0, 3, 1, 1, 1, 1);
        #1;
        chk("R10", "issue low", longint'(issue), 0);
        chk("R10", "stall low", longint'(stall), 0);
        chk("R10", "cause zero", longint'(stall_cause), 0);
        tick();
        #1;
        chk("R10", "reservations only shifted", longint'(wb_resv), 32'h200000);
        chk("R10", "pending unchanged", longint'(pend_mask), 32'h2);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ring();
        t_div();
        t_pipe();
        t_raw();
        t_waw();
        t_port();
        t_prio();
        t_nowrite();
        t_invalid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule